// File: doc/BRIEF.md
# Errored Packet Insertion Controller

This block sits next to a packet transmitter. It decides which outgoing packets get marked for deliberate corruption. The transmitter pulses `pktStrobe` once per packet boundary. One cycle later the block answers on `pktErr`, which says whether that packet should be damaged. The corruption itself happens elsewhere.

Two sources can ask for an errored packet, and their requests are ORed:

- **Automatic insertion.** It runs at a programmed rate of one packet in every x·10^y. The rate code is split into a 4-bit mantissa and a 3-bit exponent. Automatic insertion starts on a software start pulse. It runs either for a programmed number of errored packets or without end.
- **Manual insertion.** It is triggered by a rising edge on an input pin, and only while manual mode is enabled.

When a limited run finishes, a sticky done flag is set. The flag is cleared by software, and it can drive an interrupt.

Top module: `errpkt_inserter`

## Requirements
- R1: After reset, `pktErr`, `doneFlag` and `doneIrq` are 0.
- R2: `cfgRate[3:0]` is the mantissa x and `cfgRate[6:4]` is the exponent y. After a start, automatic insertion errors exactly the packets numbered k·x·10^y (k = 1, 2, …), counting from 1 at the first strobe. Codes 01h, 0Fh and 11h therefore error every packet, every 15th packet and every 10th packet.
- R3: Exponent values above 6 act as 6, so codes 6xh and 7xh give the same period. The decimal base is the parameter `RATE_BASE` (default 10).
- R4: A mantissa of 0 produces no automatic errors and never sets the done flag, whatever the exponent.
- R5: While `cfgManualEn` is 1, each 0-to-1 transition of `manualPin` marks the next packet as errored. Several edges before one strobe count once. An edge in the same cycle as a strobe applies to that packet. While `cfgManualEn` is 0, edges are ignored.
- R6: Manual and automatic requests are ORed. A packet hit by both is flagged once. Manual errors neither shift the automatic period nor use up the insertion count.
- R7: Automatic insertion happens only after an `armSet` pulse, and it stops after an `armClr` pulse. The rate and count are captured at `armSet`.
- R8: An insertion count of FFh runs without end and never sets done. Any other count N stops automatic insertion after N errored packets and sets `doneFlag`.
- R9: `doneFlag` stays set until a `doneClr` pulse. `doneIrq` is high exactly while both `doneFlag` and `cfgDoneIe` are 1.
- R10: Starting with an insertion count of 0 sets `doneFlag` at once, and no automatic error follows.
- R11: `pktErr` is a one-cycle pulse. It appears in the cycle after the strobe of the packet it marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRate | input | 7 | Rate code: mantissa [3:0], exponent [6:4] |
| cfgCount | input | 8 | Number of errored packets, FFh = continuous |
| cfgManualEn | input | 1 | Enables manual insertion |
| cfgDoneIe | input | 1 | Interrupt enable for the done flag |
| armSet | input | 1 | Start pulse (write of 1 to the start bit) |
| armClr | input | 1 | Stop pulse (clearing the start bit) |
| doneClr | input | 1 | Write-1-to-clear pulse for the done flag |
| manualPin | input | 1 | Manual insert request, rising-edge active |
| pktStrobe | input | 1 | One pulse per packet boundary |
| pktErr | output | 1 | Marks the packet of the previous cycle's strobe as errored |
| doneFlag | output | 1 | Sticky completion flag |
| doneIrq | output | 1 | Completion interrupt |

## Verification
The embedded properties check several rules on every cycle:

- an error flag never appears without a strobe in the cycle before;
- no error comes out while the block is stopped and no manual request is pending;
- the done flag is sticky, and the interrupt never rises without it;
- the period counter stays below its largest legal load;
- the remaining count never underflows.

Whether the right packets are chosen can only be shown by the directed scenarios. These cover the period for each rate code, the exponent clamp, collapsing of manual edges, OR-merging with automatic errors and the count limit.

// File: rtl/epi_pkg.sv
package epi_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // snapshot config and load period from live config
    logic loadPeriod;  // reload period from snapshot
    logic decPeriod;   // count one packet down
    logic decRemain;   // one automatic error consumed
  } epiStrobe_t;

  // Largest period load value for a given base and exponent cap
  function automatic longint maxPeriod(input int base, input int cap);
    longint acc;
    acc = 15;
    for (int i = 0; i < cap; i++) acc = acc * base;
    return acc - 1;
  endfunction

endpackage

// File: rtl/epi_datapath.sv
module epi_datapath
  import epi_pkg::*;
#(
  parameter int RATE_BASE = 10,
  parameter int EXP_CAP   = 6,
  parameter int CNT_W     = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  epiStrobe_t strb,
  input  logic [6:0] cfgRate,
  input  logic [7:0] cfgCount,
  output logic       periodZero,
  output logic       mantNz,
  output logic       remainOne,
  output logic       remainNz
);

  localparam longint MAX_LOAD = maxPeriod(RATE_BASE, EXP_CAP);
  localparam int     PROD_W   = CNT_W + 4;

  logic [6:0]       rateSnap;
  logic [CNT_W-1:0] period;
  logic [7:0]       remain;

  logic [6:0]       rateSrc;
  logic [2:0]       expEff;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0] loadVal;

  function automatic logic [CNT_W-1:0] scale(input logic [2:0] e);
    logic [CNT_W-1:0] acc;
    acc = CNT_W'(1);
    for (int i = 0; i < 7; i++) begin
      if (i < int'(e)) acc = acc * CNT_W'(RATE_BASE);
    end
    return acc;
  endfunction

  always_comb begin
    rateSrc = strb.capture ? cfgRate : rateSnap;
    expEff  = (rateSrc[6:4] > 3'(EXP_CAP)) ? 3'(EXP_CAP) : rateSrc[6:4];
    prod    = {{CNT_W{1'b0}}, rateSrc[3:0]} * {4'b0000, scale(expEff)};
    loadVal = (rateSrc[3:0] == 4'd0) ? '0 : (prod[CNT_W-1:0] - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSnap <= '0;
      period   <= '0;
      remain   <= '0;
    end else begin
      if (strb.capture) begin
        rateSnap <= cfgRate;
        remain   <= cfgCount;
      end else if (strb.decRemain) begin
        remain <= remain - 8'd1;
      end
      if (strb.capture || strb.loadPeriod) period <= loadVal;
      else if (strb.decPeriod)             period <= period - CNT_W'(1);
    end
  end

  assign periodZero = (period == '0);
  assign mantNz     = (rateSnap[3:0] != 4'd0);
  assign remainOne  = (remain == 8'd1);
  assign remainNz   = (remain != 8'd0);

  // R2: period counter never exceeds the largest legal load
  p_period_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    longint'(period) <= MAX_LOAD);

  // R8: remaining count is never decremented from zero
  p_remain_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.decRemain |-> remain != 8'd0);

endmodule

// File: rtl/epi_ctrl.sv
module epi_ctrl
  import epi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgCount,
  input  logic       cfgManualEn,
  input  logic       cfgDoneIe,
  input  logic       armSet,
  input  logic       armClr,
  input  logic       doneClr,
  input  logic       manualPin,
  input  logic       pktStrobe,
  input  logic       periodZero,
  input  logic       mantNz,
  input  logic       remainOne,
  input  logic       remainNz,
  output epiStrobe_t strb,
  output logic       pktErr,
  output logic       doneFlag,
  output logic       doneIrq
);

  logic armed;
  logic contMode;
  logic pinPrev;
  logic manPending;
  logic manEdge;
  logic autoOn;
  logic autoHit;
  logic doneSet;

  always_comb begin
    manEdge = cfgManualEn && manualPin && !pinPrev;
    autoOn  = armed && mantNz && (contMode || remainNz);
    autoHit = pktStrobe && autoOn && periodZero;

    strb.capture    = armSet;
    strb.loadPeriod = autoHit && !armSet;
    strb.decPeriod  = pktStrobe && autoOn && !periodZero && !armSet;
    strb.decRemain  = autoHit && !contMode && !armSet;

    doneSet = (armSet && cfgCount == 8'h00) ||
              (autoHit && !contMode && remainOne && !armSet);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      contMode   <= 1'b0;
      pinPrev    <= 1'b0;
      manPending <= 1'b0;
      pktErr     <= 1'b0;
      doneFlag   <= 1'b0;
    end else begin
      pinPrev <= manualPin;
      if (armClr) begin
        armed <= 1'b0;
      end else if (armSet) begin
        armed    <= 1'b1;
        contMode <= (cfgCount == 8'hFF);
      end
      manPending <= (manPending || manEdge) && !pktStrobe;
      pktErr     <= pktStrobe && (autoHit || manPending || manEdge);
      if (doneSet)      doneFlag <= 1'b1;
      else if (doneClr) doneFlag <= 1'b0;
    end
  end

  assign doneIrq = doneFlag && cfgDoneIe;

  // R11: an error flag only follows a strobe
  p_err_after_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    pktErr |-> $past(pktStrobe));

  // R7: stopped block with no manual request stays quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pktStrobe && !armed && !armSet && !manPending && !manEdge) |=> !pktErr);

  // R9: done flag holds until cleared
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !doneClr) |=> doneFlag);

  // R9: interrupt never without the flag
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> doneFlag);

endmodule

// File: rtl/errpkt_inserter.sv
module errpkt_inserter
  import epi_pkg::*;
#(
  parameter int RATE_BASE = 10,
  parameter int EXP_CAP   = 6,
  parameter int CNT_W     = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [6:0] cfgRate,
  input  logic [7:0] cfgCount,
  input  logic       cfgManualEn,
  input  logic       cfgDoneIe,
  input  logic       armSet,
  input  logic       armClr,
  input  logic       doneClr,
  input  logic       manualPin,
  input  logic       pktStrobe,
  output logic       pktErr,
  output logic       doneFlag,
  output logic       doneIrq
);

  epiStrobe_t strb;
  logic periodZero;
  logic mantNz;
  logic remainOne;
  logic remainNz;

  epi_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCount   (cfgCount),
    .cfgManualEn(cfgManualEn),
    .cfgDoneIe  (cfgDoneIe),
    .armSet     (armSet),
    .armClr     (armClr),
    .doneClr    (doneClr),
    .manualPin  (manualPin),
    .pktStrobe  (pktStrobe),
    .periodZero (periodZero),
    .mantNz     (mantNz),
    .remainOne  (remainOne),
    .remainNz   (remainNz),
    .strb       (strb),
    .pktErr     (pktErr),
    .doneFlag   (doneFlag),
    .doneIrq    (doneIrq)
  );

  epi_datapath #(
    .RATE_BASE(RATE_BASE),
    .EXP_CAP  (EXP_CAP),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgRate   (cfgRate),
    .cfgCount  (cfgCount),
    .periodZero(periodZero),
    .mantNz    (mantNz),
    .remainOne (remainOne),
    .remainNz  (remainNz)
  );

endmodule

// File: tb/errpkt_inserter_tb.sv
module errpkt_inserter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] cfgRate = '0;
  logic [7:0] cfgCount = '0;
  logic       cfgManualEn = 1'b0;
  logic       cfgDoneIe = 1'b0;
  logic       armSet = 1'b0;
  logic       armClr = 1'b0;
  logic       doneClr = 1'b0;
  logic       manualPin = 1'b0;
  logic       pktStrobe = 1'b0;
  logic       pktErr, doneFlag, doneIrq;
  logic       pktErrB, doneFlagB, doneIrqB;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int pktIdx = 0;
  int errA[$];
  int errB[$];

  always #2ns clk = ~clk;   // 250 MHz

  errpkt_inserter u_dut (
    .clk(clk), .rstN(rstN), .cfgRate(cfgRate), .cfgCount(cfgCount),
    .cfgManualEn(cfgManualEn), .cfgDoneIe(cfgDoneIe), .armSet(armSet),
    .armClr(armClr), .doneClr(doneClr), .manualPin(manualPin),
    .pktStrobe(pktStrobe), .pktErr(pktErr), .doneFlag(doneFlag), .doneIrq(doneIrq));

  // Base-2 instance lets the exponent clamp be seen in few packets
  errpkt_inserter #(.RATE_BASE(2), .EXP_CAP(6), .CNT_W(12)) u_dutSmall (
    .clk(clk), .rstN(rstN), .cfgRate(cfgRate), .cfgCount(cfgCount),
    .cfgManualEn(cfgManualEn), .cfgDoneIe(cfgDoneIe), .armSet(armSet),
    .armClr(armClr), .doneClr(doneClr), .manualPin(manualPin),
    .pktStrobe(pktStrobe), .pktErr(pktErrB), .doneFlag(doneFlagB), .doneIrq(doneIrqB));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearLog();
    pktIdx = 0;
    errA.delete();
    errB.delete();
  endtask

  task automatic startRun(input logic [6:0] rate, input logic [7:0] cnt);
    @(negedge clk);
    cfgRate = rate; cfgCount = cnt; armSet = 1'b1;
    @(negedge clk);
    armSet = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk); armClr = 1'b1; doneClr = 1'b1;
    @(negedge clk); armClr = 1'b0; doneClr = 1'b0;
  endtask

  task automatic runStrobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pktStrobe = 1'b1;
      @(negedge clk); pktStrobe = 1'b0;
      if (pktErr)  errA.push_back(pktIdx);
      if (pktErrB) errB.push_back(pktIdx);
      pktIdx++;
    end
  endtask

  task automatic manualEdge();
    @(negedge clk); manualPin = 1'b1;
    @(negedge clk); manualPin = 1'b0;
  endtask

  task automatic testReset();
    chk(pktErr == 0, "R1", "pktErr after reset", pktErr, 0);
    chk(doneFlag == 0, "R1", "doneFlag after reset", doneFlag, 0);
    chk(doneIrq == 0, "R1", "doneIrq after reset", doneIrq, 0);
  endtask

  task automatic testRates();
    // R2: 01h every packet
    clearLog(); startRun(7'h01, 8'hFF); runStrobes(5);
    chk(errA.size() == 5, "R2", "code 01h errors in 5", errA.size(), 5);
    stopRun();
    // R2: 0Fh every 15th
    clearLog(); startRun(7'h0F, 8'hFF); runStrobes(30);
    chk(errA.size() == 2, "R2", "code 0Fh error count", errA.size(), 2);
    if (errA.size() == 2) begin
      chk(errA[0] == 14, "R2", "code 0Fh first index", errA[0], 14);
      chk(errA[1] == 29, "R2", "code 0Fh second index", errA[1], 29);
    end
    stopRun();
    // R2: 11h every 10th
    clearLog(); startRun(7'h11, 8'hFF); runStrobes(25);
    chk(errA.size() == 2, "R2", "code 11h error count", errA.size(), 2);
    if (errA.size() == 2) chk(errA[0] == 9 && errA[1] == 19, "R2", "code 11h indices", errA[0], 9);
    stopRun();
    // R2: 23h every 300th
    clearLog(); startRun(7'h23, 8'hFF); runStrobes(600);
    chk(errA.size() == 2, "R2", "code 23h error count", errA.size(), 2);
    if (errA.size() == 2) chk(errA[0] == 299 && errA[1] == 599, "R2", "code 23h indices", errA[0], 299);
    stopRun();
  endtask

  task automatic testClamp();
    // R3: with base 2, code 71h acts as 61h, period 64
    clearLog(); startRun(7'h71, 8'hFF); runStrobes(130);
    chk(errB.size() == 2, "R3", "code 71h error count (base 2)", errB.size(), 2);
    if (errB.size() == 2) chk(errB[0] == 63 && errB[1] == 127, "R3", "code 71h indices", errB[0], 63);
    stopRun();
    clearLog(); startRun(7'h61, 8'hFF); runStrobes(70);
    chk(errB.size() == 1, "R3", "code 61h error count (base 2)", errB.size(), 1);
    if (errB.size() == 1) chk(errB[0] == 63, "R3", "code 61h index", errB[0], 63);
    stopRun();
  endtask

  task automatic testZeroMant();
    clearLog(); startRun(7'h30, 8'd3); runStrobes(40);
    chk(errA.size() == 0, "R4", "mantissa 0 errors", errA.size(), 0);
    chk(doneFlag == 0, "R4", "mantissa 0 done", doneFlag, 0);
    stopRun();
  endtask

  task automatic testStartStop();
    clearLog();
    @(negedge clk); cfgRate = 7'h01; cfgCount = 8'hFF;
    runStrobes(4);
    chk(errA.size() == 0, "R7", "errors before start", errA.size(), 0);
    startRun(7'h01, 8'hFF); runStrobes(3);
    chk(errA.size() == 3, "R7", "errors after start", errA.size(), 3);
    stopRun(); clearLog(); runStrobes(4);
    chk(errA.size() == 0, "R7", "errors after stop", errA.size(), 0);
  endtask

  task automatic testCountLimit();
    clearLog(); cfgDoneIe = 1'b0;
    startRun(7'h02, 8'd3); runStrobes(10);
    chk(errA.size() == 3, "R8", "limited run error count", errA.size(), 3);
    if (errA.size() == 3) chk(errA[0] == 1 && errA[1] == 3 && errA[2] == 5, "R8", "limited run indices", errA[2], 5);
    chk(doneFlag == 1, "R8", "done after limit", doneFlag, 1);
    chk(doneIrq == 0, "R9", "irq masked", doneIrq, 0);
    @(negedge clk); cfgDoneIe = 1'b1;
    @(negedge clk);
    chk(doneIrq == 1, "R9", "irq enabled", doneIrq, 1);
    repeat (5) @(negedge clk);
    chk(doneFlag == 1, "R9", "done sticky", doneFlag, 1);
    doneClr = 1'b1; @(negedge clk); doneClr = 1'b0;
    chk(doneFlag == 0, "R9", "done cleared", doneFlag, 0);
    chk(doneIrq == 0, "R9", "irq after clear", doneIrq, 0);
    cfgDoneIe = 1'b0;
    stopRun();
    // R8: continuous
    clearLog(); startRun(7'h01, 8'hFF); runStrobes(20);
    chk(errA.size() == 20, "R8", "continuous error count", errA.size(), 20);
    chk(doneFlag == 0, "R8", "continuous done", doneFlag, 0);
    stopRun();
  endtask

  task automatic testCountZero();
    clearLog(); startRun(7'h01, 8'd0);
    chk(doneFlag == 1, "R10", "done at start with count 0", doneFlag, 1);
    runStrobes(5);
    chk(errA.size() == 0, "R10", "errors with count 0", errA.size(), 0);
    stopRun();
  endtask

  task automatic testManual();
    clearLog(); cfgManualEn = 1'b0;
    manualEdge(); runStrobes(2);
    chk(errA.size() == 0, "R5", "edge ignored when disabled", errA.size(), 0);
    clearLog(); cfgManualEn = 1'b1;
    manualEdge(); manualEdge(); runStrobes(2);
    chk(errA.size() == 1, "R5", "two edges collapse", errA.size(), 1);
    if (errA.size() == 1) chk(errA[0] == 0, "R5", "manual index", errA[0], 0);
    // R5: edge in the strobe cycle
    clearLog();
    @(negedge clk); manualPin = 1'b1; pktStrobe = 1'b1;
    @(negedge clk); manualPin = 1'b0; pktStrobe = 1'b0;
    chk(pktErr == 1, "R5", "same-cycle edge applies", pktErr, 1);
    @(negedge clk);
    chk(pktErr == 0, "R11", "pulse lasts one cycle", pktErr, 0);
    runStrobes(1);
    chk(errA.size() == 0, "R5", "no carry after same-cycle edge", errA.size(), 0);
    // R6: manual with automatic
    clearLog(); startRun(7'h03, 8'hFF);
    manualEdge(); runStrobes(2);
    manualEdge(); runStrobes(4);
    chk(errA.size() == 3, "R6", "merged error count", errA.size(), 3);
    if (errA.size() == 3) chk(errA[0] == 0 && errA[1] == 2 && errA[2] == 5, "R6", "merged indices", errA[2], 5);
    stopRun();
    // R6: manual does not use up the count
    clearLog(); startRun(7'h02, 8'd2);
    manualEdge(); runStrobes(6);
    chk(errA.size() == 3, "R6", "count unaffected by manual", errA.size(), 3);
    if (errA.size() == 3) chk(errA[2] == 3, "R6", "last auto index", errA[2], 3);
    chk(doneFlag == 1, "R6", "done after auto limit", doneFlag, 1);
    stopRun(); cfgManualEn = 1'b0;
  endtask

  task automatic testTiming();
    clearLog(); startRun(7'h01, 8'hFF);
    @(negedge clk); pktStrobe = 1'b1;
    chk(pktErr == 0, "R11", "no flag in strobe cycle", pktErr, 0);
    @(negedge clk); pktStrobe = 1'b0;
    chk(pktErr == 1, "R11", "flag one cycle after strobe", pktErr, 1);
    @(negedge clk);
    chk(pktErr == 0, "R11", "flag drops after one cycle", pktErr, 0);
    stopRun();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRates();
    testClamp();
    testZeroMant();
    testStartStop();
    testCountLimit();
    testCountZero();
    testManual();
    testTiming();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4ns * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule